// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block holds instructions between decode and register-file writeback, so that functional units with different latencies can finish out of order while architectural state still changes in program order. Decode claims one slot per instruction and gets back a tag. The slot records whether the instruction writes a register, which register, and its PC. Each execution unit later returns a result, an exception flag and a cause code to the slot named by its tag. Only the oldest slot can retire, and only after its result has arrived. Retirement writes at most one register per cycle.

Decode can also ask, for each source operand, whether a buffered instruction still owes that register a value. The youngest such instruction wins over older ones and over the register file. The answer is either a ready value to bypass or a signal to stall.

When the oldest slot finishes with an exception, nothing is written. The faulting PC and cause come out, and every slot is discarded in that same cycle. Younger instructions that had already completed leave no trace, so the faulting instruction can be re-run from its PC. The depth must be a power of two.

Top module: `rob_commit`

## Requirements
- R1: After reset the buffer is empty: `full` is 0, `alloc_ready` is 1, `alloc_tag` is 0, and `commit_valid`, `rf_we` and `exc_valid` are 0.
- R2: A request with `alloc_valid` high while `full` is 0 takes the slot whose tag is `alloc_tag`. Tags run 0, 1, 2 … and wrap modulo DEPTH. After DEPTH allocations with no retirement, `full` is 1 and `alloc_ready` is 0. A request made while full is dropped, and a later lookup of its register misses.
- R3: Any of the NWB writeback ports (port p uses bits `p*TAG_W` of `wb_tag` and `p*DATA_W` of `wb_data`) can complete any valid slot, in any order. Several ports may complete different slots in the same cycle.
- R4: `commit_valid` is 1 only when the oldest slot has its result and no exception. Slots retire one per cycle in allocation order, and `commit_tag` gives the tag of the retiring slot.
- R5: A retiring slot allocated with `alloc_has_dst` = 1 drives `rf_we` = 1 with its register in `rf_waddr` and its result in `rf_wdata`. A slot with `alloc_has_dst` = 0 retires with `rf_we` = 0.
- R6: For each lookup port, when one or more buffered slots write the looked-up register, `lk_hit` is 1 and the youngest such slot supplies `lk_data`. `lk_ready` is 1 once that slot's result has arrived.
- R7: A lookup whose youngest matching slot has no result yet gives `lk_hit` = 1 and `lk_ready` = 0.
- R8: A lookup gives `lk_hit` = 0 when no buffered slot writes that register, including slots that do not write a register at all.
- R9: When the oldest slot has completed with its exception flag set, `exc_valid` is 1. `exc_pc` and `exc_cause` show that slot's PC and cause. `rf_we` and `commit_valid` are both 0.
- R10: The cycle after `exc_valid`, the buffer is empty: `alloc_tag` is 0, `full` is 0 and no lookup hits. Younger slots are never written back, even if they had completed, and an allocation requested in the exception cycle is dropped.
- R11: An exception in a younger slot has no effect until that slot is the oldest. Older slots first retire normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Decode requests a slot |
| alloc_has_dst | input | 1 | Instruction writes a register |
| alloc_dst | input | REG_W | Destination register |
| alloc_pc | input | PC_W | Instruction PC |
| alloc_ready | output | 1 | A slot is free |
| alloc_tag | output | TAG_W | Tag given to the next allocation |
| full | output | 1 | All slots occupied |
| wb_valid | input | NWB | Per-port completion strobe |
| wb_tag | input | NWB*TAG_W | Per-port slot tag |
| wb_data | input | NWB*DATA_W | Per-port result |
| wb_exc | input | NWB | Per-port exception flag |
| wb_cause | input | NWB*CAUSE_W | Per-port exception cause |
| lk_reg | input | NSRC*REG_W | Source registers to look up |
| lk_hit | output | NSRC | A buffered slot writes that register |
| lk_ready | output | NSRC | Hit slot has its result |
| lk_data | output | NSRC*DATA_W | Bypass value from the youngest hit |
| commit_valid | output | 1 | Oldest slot retires this cycle |
| commit_tag | output | TAG_W | Tag of the retiring slot |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | REG_W | Register-file write address |
| rf_wdata | output | DATA_W | Register-file write data |
| exc_valid | output | 1 | Oldest slot faulted; flush this cycle |
| exc_pc | output | PC_W | PC of the faulting instruction |
| exc_cause | output | CAUSE_W | Cause of the fault |

## Verification
The assertions track occupancy and the expected allocation and retirement tags from the ports alone. On every cycle they check that `full` matches that count and that tags are handed out and retired in order. They also check that an exception cycle never writes the register file and that the following cycle starts from an empty buffer with no lookup hits. Properties that depend on data, such as which of several matching slots the bypass picks, that a completed younger result never reaches the register file after a flush, and that a deferred younger fault waits its turn, are shown only by the bench's scenarios with known values.

// File: rtl/rob_commit.sv
module rob_commit #(
  parameter int DEPTH   = 8,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 32,
  parameter int PC_W    = 32,
  parameter int CAUSE_W = 4,
  parameter int NWB     = 3,
  parameter int NSRC    = 2,
  localparam int TAG_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_valid,
  input  logic                    alloc_has_dst,
  input  logic [REG_W-1:0]        alloc_dst,
  input  logic [PC_W-1:0]         alloc_pc,
  output logic                    alloc_ready,
  output logic [TAG_W-1:0]        alloc_tag,
  output logic                    full,
  input  logic [NWB-1:0]          wb_valid,
  input  logic [NWB*TAG_W-1:0]    wb_tag,
  input  logic [NWB*DATA_W-1:0]   wb_data,
  input  logic [NWB-1:0]          wb_exc,
  input  logic [NWB*CAUSE_W-1:0]  wb_cause,
  input  logic [NSRC*REG_W-1:0]   lk_reg,
  output logic [NSRC-1:0]         lk_hit,
  output logic [NSRC-1:0]         lk_ready,
  output logic [NSRC*DATA_W-1:0]  lk_data,
  output logic                    commit_valid,
  output logic [TAG_W-1:0]        commit_tag,
  output logic                    rf_we,
  output logic [REG_W-1:0]        rf_waddr,
  output logic [DATA_W-1:0]       rf_wdata,
  output logic                    exc_valid,
  output logic [PC_W-1:0]         exc_pc,
  output logic [CAUSE_W-1:0]      exc_cause
);

  logic [DEPTH-1:0]   vld, done, hasd, excf;
  logic [REG_W-1:0]   dst   [DEPTH];
  logic [DATA_W-1:0]  res   [DEPTH];
  logic [PC_W-1:0]    pcs   [DEPTH];
  logic [CAUSE_W-1:0] cause [DEPTH];
  logic [TAG_W-1:0]   head, tail;
  logic [CNT_W-1:0]   count;

  logic head_ready, alloc_fire;

  assign full        = (count == CNT_W'(DEPTH));
  assign alloc_ready = ~full;
  assign alloc_tag   = tail;
  assign head_ready  = vld[head] & done[head];
  assign commit_valid = head_ready & ~excf[head];
  assign exc_valid    = head_ready &  excf[head];
  assign commit_tag  = head;
  assign rf_we       = commit_valid & hasd[head];
  assign rf_waddr    = dst[head];
  assign rf_wdata    = res[head];
  assign exc_pc      = pcs[head];
  assign exc_cause   = cause[head];
  assign alloc_fire  = alloc_valid & ~full & ~exc_valid;

  genvar s;
  generate
    for (s = 0; s < NSRC; s++) begin : g_lookup
      logic              hit, rdy;
      logic [DATA_W-1:0] val;
      logic [REG_W-1:0]  want;
      assign want = lk_reg[s*REG_W +: REG_W];
      always_comb begin
        hit = 1'b0;
        rdy = 1'b1;
        val = '0;
        for (int i = 0; i < DEPTH; i++) begin
          logic [TAG_W-1:0] idx;
          idx = head + TAG_W'(i);
          if (vld[idx] && hasd[idx] && dst[idx] == want) begin
            hit = 1'b1;
            rdy = done[idx];
            val = res[idx];
          end
        end
      end
      assign lk_hit[s]                  = hit;
      assign lk_ready[s]                = rdy;
      assign lk_data[s*DATA_W +: DATA_W] = val;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld   <= '0;
      done  <= '0;
      hasd  <= '0;
      excf  <= '0;
      head  <= '0;
      tail  <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        dst[i]   <= '0;
        res[i]   <= '0;
        pcs[i]   <= '0;
        cause[i] <= '0;
      end
    end else if (exc_valid) begin
      vld   <= '0;
      done  <= '0;
      excf  <= '0;
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      for (int p = 0; p < NWB; p++) begin
        if (wb_valid[p] && vld[wb_tag[p*TAG_W +: TAG_W]]) begin
          done[wb_tag[p*TAG_W +: TAG_W]]  <= 1'b1;
          res[wb_tag[p*TAG_W +: TAG_W]]   <= wb_data[p*DATA_W +: DATA_W];
          excf[wb_tag[p*TAG_W +: TAG_W]]  <= wb_exc[p];
          cause[wb_tag[p*TAG_W +: TAG_W]] <= wb_cause[p*CAUSE_W +: CAUSE_W];
        end
      end
      if (alloc_fire) begin
        vld[tail]  <= 1'b1;
        done[tail] <= 1'b0;
        excf[tail] <= 1'b0;
        hasd[tail] <= alloc_has_dst;
        dst[tail]  <= alloc_dst;
        pcs[tail]  <= alloc_pc;
        tail       <= tail + 1'b1;
      end
      if (commit_valid) begin
        vld[head]  <= 1'b0;
        done[head] <= 1'b0;
        head       <= head + 1'b1;
      end
      count <= count + CNT_W'(alloc_fire) - CNT_W'(commit_valid);
    end
  end

endmodule

module rob_commit_chk #(
  parameter int DEPTH = 8,
  parameter int NSRC  = 2,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [TAG_W-1:0] alloc_tag,
  input logic             full,
  input logic             commit_valid,
  input logic [TAG_W-1:0] commit_tag,
  input logic             rf_we,
  input logic             exc_valid,
  input logic [NSRC-1:0]  lk_hit
);

  logic [CNT_W-1:0] occ;
  logic [TAG_W-1:0] exp_tail, exp_head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= '0; exp_tail <= '0; exp_head <= '0;
    end else if (exc_valid) begin
      occ <= '0; exp_tail <= '0; exp_head <= '0;
    end else begin
      occ      <= occ + CNT_W'(alloc_valid & alloc_ready) - CNT_W'(commit_valid);
      exp_tail <= exp_tail + TAG_W'(alloc_valid & alloc_ready);
      exp_head <= exp_head + TAG_W'(commit_valid);
    end
  end

  AST_FULL_TRACKS_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    full == (occ == CNT_W'(DEPTH)));                                         // R2
  AST_ALLOC_TAG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_tag == exp_tail);                                                  // R2
  AST_COMMIT_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> commit_tag == exp_head);                                // R4
  AST_WRITE_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> commit_valid);                                                 // R5
  AST_EXC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (!rf_we && !commit_valid));                                // R9
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (!full && alloc_tag == '0 && lk_hit == '0));               // R10

endmodule

bind rob_commit rob_commit_chk #(.DEPTH(DEPTH), .NSRC(NSRC)) u_rob_commit_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .alloc_tag(alloc_tag), .full(full), .commit_valid(commit_valid),
  .commit_tag(commit_tag), .rf_we(rf_we), .exc_valid(exc_valid), .lk_hit(lk_hit)
);

// File: tb/rob_commit_bench.sv
module rob_commit_bench;
  localparam int DEPTH = 8, REG_W = 5, DATA_W = 32, PC_W = 32, CAUSE_W = 4;
  localparam int NWB = 3, NSRC = 2, TAG_W = 3;

  // row: {has_dst, dst, result}
  localparam logic [37:0] VEC [8] = '{
    {1'b1, 5'd3,  32'h1111_0003},
    {1'b1, 5'd7,  32'h2222_0007},
    {1'b0, 5'd9,  32'h0000_0000},
    {1'b1, 5'd3,  32'h4444_0003},
    {1'b1, 5'd12, 32'hA5A5_000C},
    {1'b0, 5'd1,  32'h0000_0000},
    {1'b1, 5'd31, 32'hFFFF_001F},
    {1'b1, 5'd0,  32'h0BAD_0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, alloc_has_dst = 0;
  logic [REG_W-1:0] alloc_dst = '0;
  logic [PC_W-1:0] alloc_pc = '0;
  logic alloc_ready, full, commit_valid, rf_we, exc_valid;
  logic [TAG_W-1:0] alloc_tag, commit_tag;
  logic [NWB-1:0] wb_valid = '0, wb_exc = '0;
  logic [NWB*TAG_W-1:0] wb_tag = '0;
  logic [NWB*DATA_W-1:0] wb_data = '0;
  logic [NWB*CAUSE_W-1:0] wb_cause = '0;
  logic [NSRC*REG_W-1:0] lk_reg = '0;
  logic [NSRC-1:0] lk_hit, lk_ready;
  logic [NSRC*DATA_W-1:0] lk_data;
  logic [REG_W-1:0] rf_waddr;
  logic [DATA_W-1:0] rf_wdata;
  logic [PC_W-1:0] exc_pc;
  logic [CAUSE_W-1:0] exc_cause;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  rob_commit u_rob_commit (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_has_dst(alloc_has_dst),
    .alloc_dst(alloc_dst), .alloc_pc(alloc_pc), .alloc_ready(alloc_ready),
    .alloc_tag(alloc_tag), .full(full), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .wb_data(wb_data), .wb_exc(wb_exc), .wb_cause(wb_cause), .lk_reg(lk_reg),
    .lk_hit(lk_hit), .lk_ready(lk_ready), .lk_data(lk_data),
    .commit_valid(commit_valid), .commit_tag(commit_tag), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .exc_valid(exc_valid),
    .exc_pc(exc_pc), .exc_cause(exc_cause)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic set_wb(input int p, input int tag, input logic [31:0] d,
                        input logic e, input logic [3:0] c);
    wb_valid[p] = 1'b1;
    wb_tag[p*TAG_W +: TAG_W] = TAG_W'(tag);
    wb_data[p*DATA_W +: DATA_W] = d;
    wb_exc[p] = e;
    wb_cause[p*CAUSE_W +: CAUSE_W] = c;
  endtask

  task automatic set_alloc(input logic has, input logic [4:0] d, input logic [31:0] pc);
    alloc_valid = 1'b1; alloc_has_dst = has; alloc_dst = d; alloc_pc = pc;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 full", full, 0);
    chk("R1 alloc_ready", alloc_ready, 1);
    chk("R1 alloc_tag", alloc_tag, 0);
    chk("R1 commit_valid", commit_valid, 0);
    chk("R1 rf_we", rf_we, 0);
    chk("R1 exc_valid", exc_valid, 0);

    // table walk: allocate every row
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      set_alloc(VEC[i][37], VEC[i][36:32], 32'h100 + 32'(4*i));
      #1 chk("R2 alloc_tag sequence", alloc_tag, 64'(i));
      chk("R2 alloc_ready", alloc_ready, 1);
      @(posedge clk);
    end
    @(negedge clk);
    set_alloc(1'b1, 5'd20, 32'hDEAD);
    #1 chk("R2 full after DEPTH", full, 1);
    chk("R2 alloc_ready low", alloc_ready, 0);
    @(negedge clk);
    alloc_valid = 0;
    lk_reg[0 +: REG_W] = 5'd20;
    lk_reg[REG_W +: REG_W] = 5'd9;
    #1 chk("R2 refused alloc not buffered", lk_hit[0], 0);
    chk("R8 no-dst slot not matched", lk_hit[1], 0);
    lk_reg[0 +: REG_W] = 5'd3;
    #1 chk("R7 pending hit", lk_hit[0], 1);
    chk("R7 not ready", lk_ready[0], 0);

    // complete out of order, youngest first
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      set_wb(i % NWB, i, VEC[i][31:0], 1'b0, 4'd0);
      @(posedge clk);
      @(negedge clk);
      wb_valid = '0;
      #1;
      if (i != 0) chk("R4 no commit before head done", commit_valid, 0);
      if (i == 3) begin
        chk("R6 newest hit", lk_hit[0], 1);
        chk("R6 ready", lk_ready[0], 1);
        chk("R6 newest data", lk_data[0 +: DATA_W], VEC[3][31:0]);
      end
      if (i == 2) chk("R3 data on port 2", lk_data[0 +: DATA_W], VEC[3][31:0]);
    end
    for (int k = 0; k < 8; k++) begin
      if (k > 0) begin @(negedge clk); #1; end
      chk("R4 commit_valid", commit_valid, 1);
      chk("R4 commit_tag order", commit_tag, 64'(k));
      chk("R5 rf_we follows dst flag", rf_we, 64'(VEC[k][37]));
      if (VEC[k][37]) begin
        chk("R5 rf_waddr", rf_waddr, 64'(VEC[k][36:32]));
        chk("R5 rf_wdata", rf_wdata, 64'(VEC[k][31:0]));
      end
    end
    @(negedge clk); #1;
    chk("R4 drained", commit_valid, 0);
    chk("R8 miss after drain", lk_hit[0], 0);
    chk("R2 not full after drain", full, 0);

    // precise exception
    @(negedge clk); set_alloc(1'b1, 5'd4, 32'h200); @(posedge clk);
    @(negedge clk); set_alloc(1'b1, 5'd5, 32'h204); @(posedge clk);
    @(negedge clk); set_alloc(1'b1, 5'd6, 32'h208); @(posedge clk);
    @(negedge clk); set_alloc(1'b1, 5'd7, 32'h20C); @(posedge clk);
    @(negedge clk);
    alloc_valid = 0;
    set_wb(0, 2, 32'hC0C0_0006, 1'b0, 4'd0);
    set_wb(1, 3, 32'hD0D0_0007, 1'b1, 4'd2);
    @(posedge clk);
    @(negedge clk);
    wb_valid = '0;
    set_wb(2, 1, 32'hBBBB_0005, 1'b1, 4'd9);
    lk_reg[0 +: REG_W] = 5'd6;
    #1 chk("R3 same-cycle completion hit", lk_hit[0], 1);
    chk("R3 same-cycle completion ready", lk_ready[0], 1);
    chk("R3 same-cycle completion data", lk_data[0 +: DATA_W], 32'hC0C0_0006);
    chk("R11 younger fault waits", exc_valid, 0);
    chk("R11 no commit yet", commit_valid, 0);
    @(posedge clk);
    @(negedge clk);
    wb_valid = '0;
    set_wb(0, 0, 32'hAAAA_0004, 1'b0, 4'd0);
    #1 chk("R11 fault not at head", exc_valid, 0);
    @(posedge clk);
    @(negedge clk);
    wb_valid = '0;
    #1 chk("R11 older commits first", rf_we, 1);
    chk("R11 older waddr", rf_waddr, 4);
    chk("R11 older wdata", rf_wdata, 32'hAAAA_0004);
    chk("R11 no exception yet", exc_valid, 0);
    @(posedge clk);
    @(negedge clk);
    set_alloc(1'b1, 5'd20, 32'h300);
    #1 chk("R9 exc_valid", exc_valid, 1);
    chk("R9 exc_pc", exc_pc, 32'h204);
    chk("R9 exc_cause", exc_cause, 9);
    chk("R9 no rf write", rf_we, 0);
    chk("R9 no commit", commit_valid, 0);
    @(posedge clk);
    @(negedge clk);
    alloc_valid = 0;
    lk_reg[REG_W +: REG_W] = 5'd20;
    #1 chk("R10 completed younger discarded", lk_hit[0], 0);
    chk("R10 alloc in fault cycle dropped", lk_hit[1], 0);
    chk("R10 tag restarts", alloc_tag, 0);
    chk("R10 not full", full, 0);
    chk("R10 no retire of younger", rf_we, 0);
    chk("R10 no second exception", exc_valid, 0);

    // restart from the faulting PC
    @(negedge clk); set_alloc(1'b1, 5'd6, 32'h204); @(posedge clk);
    @(negedge clk); alloc_valid = 0; set_wb(1, 0, 32'h5A5A_0006, 1'b0, 4'd0); @(posedge clk);
    @(negedge clk); wb_valid = '0;
    #1 chk("R10 restart commits", rf_we, 1);
    chk("R10 restart waddr", rf_waddr, 6);
    chk("R10 restart wdata", rf_wdata, 32'h5A5A_0006);

    // reset mid-stream returns to empty
    @(negedge clk); set_alloc(1'b1, 5'd8, 32'h400); @(posedge clk);
    @(negedge clk); alloc_valid = 0; rst_n = 1'b0;
    #1 chk("R1 reset clears tag", alloc_tag, 0);
    chk("R1 reset no commit", commit_valid, 0);
    @(negedge clk); rst_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule